// File: doc/BRIEF.md
# SMBus Host Register File

This block holds the host-side registers of an SMBus controller behind an eight-byte I/O window. Software reaches a status register, a control register, a command register, a target-address register and two data registers, each one byte wide. A buffer of block data is reached through one port that steps through the buffer by itself. The block does not drive the SMBus wires. A write to the control register produces a one-cycle start request that a separate transaction engine can use.

The buffer port keeps an internal index. Each read or write of the port uses the entry at that index and then moves the index forward by one. After the last entry the index returns to entry 0. Software can move the index back to entry 0 in two ways: by reading the control register, or by writing the status register. Writes to the scalar registers clear them; the value written is not stored. Read data is registered, so it appears on `rdata` one cycle after the read strobe.

Top module: `smbus_host_regs`

## Requirements
- R1: During and after a synchronous reset, `rdata` is 0, `start_o` is 0, the buffer index is 0, and every buffer entry reads back as 0.
- R2: A read of the control register at offset 2 returns only its low 5 bits, with the upper bits as 0. It also sets the buffer index to 0.
- R3: A write to the status register at offset 0 clears the status register and sets the buffer index to 0.
- R4: A read or write of offset 7 accesses the buffer entry at the current index and then adds one to the index. After the entry at DEPTH-1 is accessed, the index returns to 0.
- R5: A write to offset 2, 3, 4, 5 or 6 clears that register, whatever the write data is. A later read of that offset returns 0.
- R6: A write to offset 2 drives `start_o` high for exactly one cycle. It goes high on the clock edge that takes the write.
- R7: A read of offset 1, which has no register, returns 0.
- R8: `rdata` takes its new value on the clock edge that takes the read strobe. It keeps that value until the next read.
- R9: A buffer entry written through offset 7 reads back through offset 7 as the byte that was written.
- R10: `rd_en` and `wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | AW (3) | Byte offset inside the window |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Registered read data |
| start_o | output | 1 | One-cycle start request after a control write |

## Verification
The buffer index is internal state that cannot be seen directly. When the index is wrong, the port shows it on the very next offset-7 read: the byte returned belongs to the wrong position in the known pattern. The sweep therefore writes a distinct byte to every entry and rewinds the index. It then reads all the entries and one more, which shows any error in stepping or wrapping within one pass. A rewind that fails, from either a control read or a status write, shows up on the first block read after it. An entry left set after reset shows up as a nonzero byte in a full sweep of the buffer.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] OFF_STS = 3'd0;
  localparam logic [AW-1:0] OFF_CTL = 3'd2;
  localparam logic [AW-1:0] OFF_CMD = 3'd3;
  localparam logic [AW-1:0] OFF_TGT = 3'd4;
  localparam logic [AW-1:0] OFF_DA0 = 3'd5;
  localparam logic [AW-1:0] OFF_DA1 = 3'd6;
  localparam logic [AW-1:0] OFF_BLK = 3'd7;

  typedef struct packed {
    logic rd_ctl;
    logic rd_blk;
    logic wr_sts;
    logic wr_ctl;
    logic wr_cmd;
    logic wr_tgt;
    logic wr_da0;
    logic wr_da1;
    logic wr_blk;
  } smbh_dec_t;
endpackage

// File: rtl/smbh_decode.sv
module smbh_decode
  import smbh_pkg::*;
(
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output smbh_dec_t     dec
);
  always_comb begin
    dec        = '0;
    dec.rd_ctl = rd_en && (addr == OFF_CTL);
    dec.rd_blk = rd_en && (addr == OFF_BLK);
    dec.wr_sts = wr_en && (addr == OFF_STS);
    dec.wr_ctl = wr_en && (addr == OFF_CTL);
    dec.wr_cmd = wr_en && (addr == OFF_CMD);
    dec.wr_tgt = wr_en && (addr == OFF_TGT);
    dec.wr_da0 = wr_en && (addr == OFF_DA0);
    dec.wr_da1 = wr_en && (addr == OFF_DA1);
    dec.wr_blk = wr_en && (addr == OFF_BLK);
  end
endmodule

// File: rtl/smbh_scalar.sv
module smbh_scalar
  import smbh_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CTL_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  smbh_dec_t     dec,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rd_val,
  output logic          start_o
);
  localparam logic [DW-1:0] CTL_MASK = DW'((1 << CTL_BITS) - 1);

  logic [DW-1:0] sts_q, ctl_q, cmd_q, tgt_q, da0_q, da1_q;

  // Software writes clear these registers; the written value is not stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= '0;
      ctl_q   <= '0;
      cmd_q   <= '0;
      tgt_q   <= '0;
      da0_q   <= '0;
      da1_q   <= '0;
      start_o <= 1'b0;
    end else begin
      if (dec.wr_sts) sts_q <= '0;
      if (dec.wr_ctl) ctl_q <= '0;
      if (dec.wr_cmd) cmd_q <= '0;
      if (dec.wr_tgt) tgt_q <= '0;
      if (dec.wr_da0) da0_q <= '0;
      if (dec.wr_da1) da1_q <= '0;
      start_o <= dec.wr_ctl;
    end
  end

  always_comb begin
    unique case (addr)
      OFF_STS: rd_val = sts_q;
      OFF_CTL: rd_val = ctl_q & CTL_MASK;
      OFF_CMD: rd_val = cmd_q;
      OFF_TGT: rd_val = tgt_q;
      OFF_DA0: rd_val = da0_q;
      OFF_DA1: rd_val = da1_q;
      default: rd_val = '0;
    endcase
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o || $past(dec.wr_ctl)); // R6
  AST_START_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    dec.wr_ctl |=> start_o); // R6
endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf
  import smbh_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  smbh_dec_t     dec,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_byte
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx_q;
  logic          step;
  logic          rewind;

  assign step    = dec.rd_blk || dec.wr_blk;
  assign rewind  = dec.rd_ctl || dec.wr_sts;
  assign rd_byte = mem[idx_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (rewind) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  // Reset clears every entry, so the array stays in fabric registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (dec.wr_blk) begin
      mem[idx_q] <= wdata;
    end
  end

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && idx_q == LAST) |=> idx_q == '0); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && idx_q != LAST) |=> idx_q == $past(idx_q) + 1'b1); // R4
  AST_IDX_REWIND: assert property (@(posedge clk) disable iff (rst)
    rewind |=> idx_q == '0); // R2 R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !rewind) |=> $stable(idx_q)); // R4
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbh_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEPTH    = 32,
  parameter int CTL_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          start_o
);
  smbh_dec_t     dec;
  logic [DW-1:0] reg_val;
  logic [DW-1:0] blk_val;

  smbh_decode u_dec (
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .dec   (dec)
  );

  smbh_scalar #(.DW(DW), .CTL_BITS(CTL_BITS)) u_scalar (
    .clk     (clk),
    .rst     (rst),
    .dec     (dec),
    .addr    (addr),
    .rd_val  (reg_val),
    .start_o (start_o)
  );

  smbh_blkbuf #(.DW(DW), .DEPTH(DEPTH)) u_blk (
    .clk     (clk),
    .rst     (rst),
    .dec     (dec),
    .wdata   (wdata),
    .rd_byte (blk_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= (addr == OFF_BLK) ? blk_val : reg_val;
    end
  end

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R8
  AST_UNIMP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd1) |=> rdata == '0); // R7
  AST_CTL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFF_CTL) |=> rdata[DW-1:CTL_BITS] == '0); // R2
endmodule

// File: tb/smbus_host_regs_bench.sv
module smbus_host_regs_bench;
  localparam int DW = 8;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic start_o;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  smbus_host_regs u_smbus_host_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .start_o(start_o)
  );

  function automatic logic [DW-1:0] pat(int i, int seed);
    return DW'(i * 7 + seed * 29 + 3);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [2:0] a, logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [2:0] a, output logic [DW-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    check("R1 rdata reset", rdata, '0);
    check("R1 start reset", {7'd0, start_o}, '0);
    rst = 1'b0;
    @(negedge clk);

    // R1: every entry zero after reset
    for (int i = 0; i < DEPTH; i++) begin
      do_rd(3'd7, v); check("R1 buffer zero", v, '0);
    end

    // R9 R4: fill with several patterns, rewind by status write, read back + wrap
    for (int s = 0; s < 3; s++) begin
      do_wr(3'd0, 8'hFF);
      for (int i = 0; i < DEPTH; i++) do_wr(3'd7, pat(i, s));
      do_wr(3'd0, 8'hA5); // R3 rewind
      for (int i = 0; i < DEPTH; i++) begin
        do_rd(3'd7, v); check("R9 R4 readback", v, pat(i, s));
      end
      do_rd(3'd7, v); check("R4 wrap to entry 0", v, pat(0, s));
    end

    // R4: writes wrap too: DEPTH+2 writes land entries 0,1 with new values
    do_wr(3'd0, 8'h00);
    for (int i = 0; i < DEPTH + 2; i++) do_wr(3'd7, (i >= DEPTH) ? pat(i, 9) : pat(i, 2));
    do_wr(3'd0, 8'h00);
    do_rd(3'd7, v); check("R4 write wrap e0", v, pat(DEPTH, 9));
    do_rd(3'd7, v); check("R4 write wrap e1", v, pat(DEPTH + 1, 9));
    do_rd(3'd7, v); check("R4 write wrap e2", v, pat(2, 2));

    // R2: control read rewinds at each stop point and returns masked zero
    for (int k = 1; k < 6; k++) begin
      for (int i = 0; i < k; i++) do_rd(3'd7, v);
      do_rd(3'd2, v); check("R2 ctl read value", v, '0);
      do_rd(3'd7, v); check("R2 ctl read rewinds", v, pat(DEPTH, 9));
    end

    // R3: status write rewinds mid-stream, status reads zero
    do_rd(3'd7, v); do_rd(3'd7, v);
    do_wr(3'd0, 8'h3C);
    do_rd(3'd0, v); check("R3 status cleared", v, '0);
    do_rd(3'd7, v); check("R3 status write rewinds", v, pat(DEPTH, 9));

    // R5: writes to 2..6 clear regardless of data; R8 hold
    for (int a = 2; a <= 6; a++) begin
      do_wr(3'(a), 8'hFF);
      do_rd(3'(a), v); check("R5 write clears", v, '0);
    end
    // R5: scalar writes do not move the index
    do_wr(3'd0, 8'h00);
    for (int a = 3; a <= 6; a++) do_wr(3'(a), 8'h77);
    do_rd(3'd7, v); check("R5 index untouched", v, pat(DEPTH, 9));
    repeat (3) @(negedge clk);
    check("R8 rdata holds", rdata, pat(DEPTH, 9));

    // R7
    do_rd(3'd1, v); check("R7 offset1 zero", v, '0);

    // R6 start pulse
    check("R6 start idle", {7'd0, start_o}, '0);
    addr = 3'd2; wdata = 8'h1F; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R6 start high", {7'd0, start_o}, 8'd1);
    @(negedge clk);
    check("R6 start one cycle", {7'd0, start_o}, '0);
    do_wr(3'd3, 8'h01);
    check("R6 no start other offset", {7'd0, start_o}, '0);

    // R1: mid-run reset clears buffer
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      do_rd(3'd7, v); check("R1 buffer cleared by reset", v, '0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule